// File: doc/BRIEF.md
# Synthesizer Divider Configuration Controller

This block owns the divider settings of a frequency synthesizer: a 10-bit feedback divider, a 1-bit predivider code, a 3-bit output postdivider code and a 1-bit secondary-output divider select. It keeps two sets of storage. The live divider latches drive the synthesizer. Two byte-wide shadow registers are what a serial slave reads and writes. Byte commands move data between the two sets, or step the feedback divider in place for frequency margining.

A mode input picks the source of the settings. While it is low, the dividers track a 15-bit parallel pin bus cycle by cycle and the shadow registers mirror them, so serial writes and commands have no effect. While it is high, the pins are ignored and the serial port has control. An active-low master reset returns everything to the default setting. On its release the dividers capture the pins, whatever the mode. A one-cycle strobe flags every change of the feedback divider or the predivider, so downstream lock logic can restart.

Top module: `synth_divcfg_ctrl`

## Requirements
- R1: While `mr_n` is low (or `rst` is high), the dividers hold the default setting on the next clock: M=500, NA code 3'b010, NB=0, P=1. While `mr_n` is low, `rd_data` reads 0.
- R2: In the first cycle with `mr_n` high after a cycle with it low, the dividers and shadow registers load the pin values, whatever the level of `pload`.
- R3: While `pload` is low, the dividers take the pin values on each clock edge and the shadow registers mirror them. This includes the first cycle after a falling `pload` edge.
- R4: While `pload` is low, register writes and commands change neither the dividers nor the shadow registers.
- R5: After `pload` rises, and while it stays high, pin changes do not affect the dividers. The dividers change only through commands.
- R6: Register layout. Register 0 (`wr_sel`/`rd_sel` = 0) holds M[7:0]. Register 1 holds, from bit 7 down to bit 0: M9, M8, NA2, NA1, NA0, NB, P, LOCK.
- R7: Command 8'h04 copies both shadow registers into the dividers.
- R8: Command 8'h08 copies the dividers into the shadow registers.
- R9: Command 8'h01 adds one to M and command 8'h02 subtracts one from M, modulo 1024 with no range check. The shadow registers are left unchanged.
- R10: Bit 0 of register 1 reads the current `lock_in` level. Write data in that bit position is discarded.
- R11: When a write and a command arrive in the same cycle, the command is performed and the write is dropped.
- R12: `config_changed` is high for exactly the cycles in which the M or P divider output differs from its value in the previous cycle.
- R13: A command byte other than 8'h01, 8'h02, 8'h04 or 8'h08 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mr_n | input | 1 | Master reset, active low; its release loads the pins |
| pload | input | 1 | Mode select: 0 selects the parallel pins, 1 selects the serial port |
| pin_m | input | 10 | Parallel feedback divider value |
| pin_na | input | 3 | Parallel postdivider code |
| pin_nb | input | 1 | Parallel secondary divider select |
| pin_p | input | 1 | Parallel predivider code |
| lock_in | input | 1 | PLL lock status |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 selects the low register, 1 the high register |
| wr_data | input | 8 | Write data |
| cmd_en | input | 1 | Command strobe |
| cmd_code | input | 8 | Command byte |
| rd_sel | input | 1 | Read target: 0 selects the low register, 1 the high register |
| rd_data | output | 8 | Register readback (combinational) |
| div_m | output | 10 | Live feedback divider |
| div_na | output | 3 | Live postdivider code |
| div_nb | output | 1 | Live secondary divider select |
| div_p | output | 1 | Live predivider code |
| config_changed | output | 1 | One-cycle strobe on a change of M or P |

## Verification
A live latch that is wrong shows on `div_m`, `div_na`, `div_nb` and `div_p` one edge after the stimulus. Wrong shadow storage stays hidden until it is read through `rd_data` or copied into the dividers by a load command, so every command test reads both registers back. The strobe is compared against the divider outputs every cycle, which exposes a missed or extra change at once. Wrap-around, same-cycle write and command, the lock bit and both mode edges are each driven separately.

// File: rtl/synth_divcfg_pkg.sv
package synth_divcfg_pkg;

    localparam int M_W    = 10;
    localparam int NA_W   = 3;
    localparam int BYTE_W = 8;
    localparam int M_LO_W = BYTE_W;
    localparam int M_HI_W = M_W - M_LO_W;

    typedef logic [M_W-1:0] m_t;

    typedef struct packed {
        m_t            m;
        logic [NA_W-1:0] na;
        logic          nb;
        logic          p;
    } div_cfg_t;

    localparam div_cfg_t CFG_DEFAULT = '{m: 10'd500, na: 3'b010, nb: 1'b0, p: 1'b1};

    localparam logic [BYTE_W-1:0] OP_INC  = 8'h01;
    localparam logic [BYTE_W-1:0] OP_DEC  = 8'h02;
    localparam logic [BYTE_W-1:0] OP_LOAD = 8'h04;
    localparam logic [BYTE_W-1:0] OP_GET  = 8'h08;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_INC,
        ACT_DEC,
        ACT_LOAD,
        ACT_GET
    } act_e;

    function automatic logic [BYTE_W-1:0] lo_byte(input div_cfg_t c);
        return c.m[M_LO_W-1:0];
    endfunction

    function automatic logic [BYTE_W-1:0] hi_byte(input div_cfg_t c, input logic lock);
        return {c.m[M_W-1:M_LO_W], c.na, c.nb, c.p, lock};
    endfunction

endpackage

// File: rtl/divcfg_cmd_decode.sv
module divcfg_cmd_decode
    import synth_divcfg_pkg::*;
(
    input  logic              serial_ok,
    input  logic              cmd_en,
    input  logic [BYTE_W-1:0] cmd_code,
    input  logic              wr_en,
    input  logic              wr_sel,
    output act_e              act,
    output logic              wr_lo,
    output logic              wr_hi
);

    always_comb begin
        act = ACT_NONE;
        if (serial_ok && cmd_en) begin
            case (cmd_code)
                OP_INC:  act = ACT_INC;
                OP_DEC:  act = ACT_DEC;
                OP_LOAD: act = ACT_LOAD;
                OP_GET:  act = ACT_GET;
                default: act = ACT_NONE;
            endcase
        end
    end

    // a command of any code wins over a write in the same cycle
    always_comb begin
        wr_lo = serial_ok && wr_en && !cmd_en && !wr_sel;
        wr_hi = serial_ok && wr_en && !cmd_en &&  wr_sel;
    end

endmodule

// File: rtl/divcfg_latch.sv
module divcfg_latch
    import synth_divcfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     hold_def,
    input  logic     take_pins,
    input  div_cfg_t pins,
    input  div_cfg_t shadow,
    input  act_e     act,
    output div_cfg_t live,
    output logic     changed
);

    div_cfg_t nxt;

    always_comb begin
        nxt = live;
        if (hold_def) begin
            nxt = CFG_DEFAULT;
        end else if (take_pins) begin
            nxt = pins;
        end else begin
            case (act)
                ACT_LOAD: nxt = shadow;
                ACT_INC:  nxt.m = live.m + m_t'(1);
                ACT_DEC:  nxt.m = live.m - m_t'(1);
                default:  nxt = live;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live    <= CFG_DEFAULT;
            changed <= 1'b0;
        end else begin
            live    <= nxt;
            changed <= (nxt.m != live.m) || (nxt.p != live.p);
        end
    end

    // R9: INC steps M by one, wrapping at the top
    a_r9_inc_step: assert property (@(posedge clk) disable iff (rst)
        act == ACT_INC |=> live.m == $past(live.m) + m_t'(1));

    // R9: DEC steps M down by one, wrapping at zero
    a_r9_dec_step: assert property (@(posedge clk) disable iff (rst)
        act == ACT_DEC |=> live.m == $past(live.m) - m_t'(1));

    // R7: LOAD transfers the shadow contents
    a_r7_load_copy: assert property (@(posedge clk) disable iff (rst)
        act == ACT_LOAD |=> live == $past(shadow));

    // R12: strobe matches a change on M or P
    a_r12_strobe: assert property (@(posedge clk) disable iff (rst || $past(rst))
        changed == ((live.m != $past(live.m)) || (live.p != $past(live.p))));

endmodule

// File: rtl/divcfg_shadow.sv
module divcfg_shadow
    import synth_divcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_def,
    input  logic              take_pins,
    input  div_cfg_t          pins,
    input  div_cfg_t          live,
    input  act_e              act,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    output div_cfg_t          shadow
);

    always_ff @(posedge clk) begin
        if (rst || hold_def) begin
            shadow <= CFG_DEFAULT;
        end else if (take_pins) begin
            shadow <= pins;
        end else if (act == ACT_GET) begin
            shadow <= live;
        end else begin
            if (wr_lo) begin
                shadow.m[M_LO_W-1:0] <= wr_data;
            end
            if (wr_hi) begin
                // bit 0 carries the read-only lock flag and is dropped
                shadow.m[M_W-1:M_LO_W] <= wr_data[BYTE_W-1:BYTE_W-M_HI_W];
                shadow.na <= wr_data[BYTE_W-M_HI_W-1:3];
                shadow.nb <= wr_data[2];
                shadow.p  <= wr_data[1];
            end
        end
    end

    // R8: GET captures the live dividers
    a_r8_get_copy: assert property (@(posedge clk) disable iff (rst)
        act == ACT_GET |=> shadow == $past(live));

    // R9, R11: INC, DEC and LOAD leave the shadow registers untouched
    a_r11_cmd_keeps_shadow: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_INC || act == ACT_DEC || act == ACT_LOAD) |=> $stable(shadow));

endmodule

// File: rtl/synth_divcfg_ctrl.sv
module synth_divcfg_ctrl
    import synth_divcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mr_n,
    input  logic              pload,
    input  logic [M_W-1:0]    pin_m,
    input  logic [NA_W-1:0]   pin_na,
    input  logic              pin_nb,
    input  logic              pin_p,
    input  logic              lock_in,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              cmd_en,
    input  logic [BYTE_W-1:0] cmd_code,
    input  logic              rd_sel,
    output logic [BYTE_W-1:0] rd_data,
    output logic [M_W-1:0]    div_m,
    output logic [NA_W-1:0]   div_na,
    output logic              div_nb,
    output logic              div_p,
    output logic              config_changed
);

    logic     mr_q;
    logic     hold_def, take_pins, serial_ok;
    logic     wr_lo, wr_hi;
    act_e     act;
    div_cfg_t pins, live, shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            mr_q <= 1'b0;
        end else begin
            mr_q <= mr_n;
        end
    end

    always_comb begin
        pins      = '{m: pin_m, na: pin_na, nb: pin_nb, p: pin_p};
        hold_def  = !mr_n;
        take_pins = mr_n && (!mr_q || !pload);
        serial_ok = mr_n && mr_q && pload;
    end

    divcfg_cmd_decode u_dec (
        .serial_ok (serial_ok),
        .cmd_en    (cmd_en),
        .cmd_code  (cmd_code),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .act       (act),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi)
    );

    divcfg_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .hold_def  (hold_def),
        .take_pins (take_pins),
        .pins      (pins),
        .shadow    (shadow),
        .act       (act),
        .live      (live),
        .changed   (config_changed)
    );

    divcfg_shadow u_shadow (
        .clk       (clk),
        .rst       (rst),
        .hold_def  (hold_def),
        .take_pins (take_pins),
        .pins      (pins),
        .live      (live),
        .act       (act),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .wr_data   (wr_data),
        .shadow    (shadow)
    );

    always_comb begin
        div_m  = live.m;
        div_na = live.na;
        div_nb = live.nb;
        div_p  = live.p;
        if (!mr_n) begin
            rd_data = '0;
        end else if (rd_sel) begin
            rd_data = hi_byte(shadow, lock_in);
        end else begin
            rd_data = lo_byte(shadow);
        end
    end

    // R1: master reset forces the default setting
    a_r1_mr_default: assert property (@(posedge clk) disable iff (rst)
        !mr_n |=> (div_m == CFG_DEFAULT.m && div_na == CFG_DEFAULT.na &&
                   div_nb == CFG_DEFAULT.nb && div_p == CFG_DEFAULT.p));

    // R3: parallel mode tracks the pins
    a_r3_pins_follow: assert property (@(posedge clk) disable iff (rst)
        (mr_n && !pload) |=> (div_m == $past(pin_m) && div_na == $past(pin_na) &&
                              div_nb == $past(pin_nb) && div_p == $past(pin_p)));

    // R5: in serial mode with no command the dividers hold
    a_r5_serial_hold: assert property (@(posedge clk) disable iff (rst)
        (mr_n && mr_q && pload && !cmd_en) |=>
            ($stable(div_m) && $stable(div_na) && $stable(div_nb) && $stable(div_p)));

    // R10: bit 0 of the high register reflects the lock input
    a_r10_lock_bit: assert property (@(posedge clk) disable iff (rst)
        (mr_n && rd_sel) |-> rd_data[0] == lock_in);

endmodule

// File: tb/synth_divcfg_ctrl_test.sv
module synth_divcfg_ctrl_test;

    logic       clk = 1'b0;
    logic       rst, mr_n, pload, pin_nb, pin_p, lock_in;
    logic [9:0] pin_m;
    logic [2:0] pin_na;
    logic       wr_en, wr_sel, cmd_en, rd_sel;
    logic [7:0] wr_data, cmd_code, rd_data;
    logic [9:0] div_m;
    logic [2:0] div_na;
    logic       div_nb, div_p, config_changed;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    synth_divcfg_ctrl uut (
        .clk(clk), .rst(rst), .mr_n(mr_n), .pload(pload),
        .pin_m(pin_m), .pin_na(pin_na), .pin_nb(pin_nb), .pin_p(pin_p),
        .lock_in(lock_in), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cmd_en(cmd_en), .cmd_code(cmd_code), .rd_sel(rd_sel), .rd_data(rd_data),
        .div_m(div_m), .div_na(div_na), .div_nb(div_nb), .div_p(div_p),
        .config_changed(config_changed)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_div(input string req, input int m, input int na, input int nb, input int p);
        chk({req, " m"}, int'(div_m), m);
        chk({req, " na"}, int'(div_na), na);
        chk({req, " nb"}, int'(div_nb), nb);
        chk({req, " p"}, int'(div_p), p);
    endtask

    task automatic chk_rd(input string req, input bit sel, input int exp);
        rd_sel = sel;
        #1;
        chk(req, int'(rd_data), exp);
    endtask

    task automatic reg_write(input bit sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic command(input logic [7:0] c);
        cmd_en = 1'b1; cmd_code = c;
        tick();
        cmd_en = 1'b0;
    endtask

    task automatic t_reset();
        chk_div("R1 reset default", 500, 2, 0, 1);
        chk_rd("R1 read refused lo", 1'b0, 0);
        chk_rd("R1 read refused hi", 1'b1, 0);
    endtask

    task automatic t_mr_release();
        mr_n = 1'b1;
        tick();
        chk_div("R2 release capture", 10'h2A5, 5, 1, 0);
        chk("R12 strobe on release", int'(config_changed), 1);
        chk_rd("R6 lo layout", 1'b0, 8'hA5);
        chk_rd("R6 hi layout", 1'b1, 8'hAC);
        tick();
        chk("R12 strobe one cycle", int'(config_changed), 0);
    endtask

    task automatic t_serial_hold();
        pin_m = 10'h011; pin_na = 3'd0;
        tick();
        chk("R5 pins ignored in serial", int'(div_m), 10'h2A5);
    endtask

    task automatic t_write_load();
        reg_write(1'b0, 8'h34);
        reg_write(1'b1, 8'h5B);
        chk("R7 write alone keeps divider", int'(div_m), 10'h2A5);
        chk_rd("R6 lo written", 1'b0, 8'h34);
        chk_rd("R10 lock bit low", 1'b1, 8'h5A);
        lock_in = 1'b1;
        chk_rd("R10 lock bit high", 1'b1, 8'h5B);
        command(8'h04);
        chk_div("R7 load", 10'h134, 3, 0, 1);
        chk("R12 strobe on load", int'(config_changed), 1);
    endtask

    task automatic t_inc_dec();
        command(8'h01);
        chk("R9 inc", int'(div_m), 10'h135);
        chk_rd("R9 inc keeps shadow", 1'b0, 8'h34);
        command(8'h02);
        command(8'h02);
        chk("R9 dec twice", int'(div_m), 10'h133);
    endtask

    task automatic t_priority();
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h77;
        command(8'h01);
        wr_en = 1'b0;
        chk("R11 command done", int'(div_m), 10'h134);
        chk_rd("R11 write dropped", 1'b0, 8'h34);
    endtask

    task automatic t_unknown();
        command(8'h03);
        chk("R13 unknown code m", int'(div_m), 10'h134);
        chk("R13 unknown code no strobe", int'(config_changed), 0);
        chk_rd("R13 unknown code shadow", 1'b0, 8'h34);
    endtask

    task automatic t_get();
        command(8'h01);
        command(8'h08);
        chk_rd("R8 get lo", 1'b0, 8'h35);
        chk_rd("R8 get hi", 1'b1, 8'h5B);
        chk("R8 get no strobe", int'(config_changed), 0);
    endtask

    task automatic t_wrap();
        reg_write(1'b0, 8'hFF);
        reg_write(1'b1, 8'hC0);
        command(8'h04);
        chk_div("R7 load top", 1023, 0, 0, 0);
        command(8'h01);
        chk("R9 inc wraps to zero", int'(div_m), 0);
        chk("R12 strobe on wrap", int'(config_changed), 1);
        command(8'h02);
        chk("R9 dec wraps to top", int'(div_m), 1023);
    endtask

    task automatic t_parallel();
        pin_m = 10'h1F0; pin_na = 3'd1; pin_nb = 1'b1; pin_p = 1'b1;
        pload = 1'b0;
        tick();
        chk_div("R3 falling edge takes pins", 10'h1F0, 1, 1, 1);
        chk_rd("R3 mirror lo", 1'b0, 8'hF0);
        chk_rd("R3 mirror hi", 1'b1, 8'h4F);
        pin_m = 10'h1F1;
        tick();
        chk("R3 follows pin change", int'(div_m), 10'h1F1);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h00;
        command(8'h01);
        wr_en = 1'b0;
        chk("R4 command ignored", int'(div_m), 10'h1F1);
        chk_rd("R4 write ignored", 1'b0, 8'hF1);
    endtask

    task automatic t_pload_rise();
        pload = 1'b1;
        tick();
        pin_m = 10'h050; pin_na = 3'd0; pin_nb = 1'b0; pin_p = 1'b0;
        tick();
        chk_div("R5 rising edge holds", 10'h1F1, 1, 1, 1);
        chk_rd("R5 shadow holds", 1'b0, 8'hF1);
    endtask

    task automatic t_mr_again();
        mr_n = 1'b0;
        tick();
        chk_div("R1 master reset", 500, 2, 0, 1);
        chk("R12 strobe on master reset", int'(config_changed), 1);
        chk_rd("R1 read refused", 1'b0, 0);
        mr_n = 1'b1;
        tick();
        chk_div("R2 release in serial mode", 10'h050, 0, 0, 0);
    endtask

    initial begin
        rst = 1'b1; mr_n = 1'b0; pload = 1'b1; lock_in = 1'b0;
        pin_m = 10'h2A5; pin_na = 3'd5; pin_nb = 1'b1; pin_p = 1'b0;
        wr_en = 1'b0; wr_sel = 1'b0; wr_data = 8'h00;
        cmd_en = 1'b0; cmd_code = 8'h00; rd_sel = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
        repeat (2) tick();
        t_reset();
        t_mr_release();
        t_serial_hold();
        t_write_load();
        t_inc_dec();
        t_priority();
        t_unknown();
        t_get();
        t_wrap();
        t_parallel();
        t_pload_rise();
        t_mr_again();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule